// File: doc/BRIEF.md
# IPC-Targeted Pipeline Throttle Controller

This block holds a pipeline's throughput at or below a programmable instruction rate. It uses that rate as a fast, cycle-level stand-in for dynamic power. Every cycle the pipeline reports how many instructions it committed. The block keeps a running total of those counts over a sliding window of W cycles. When the total is above the target rate times W, the block starts throttling.

Throttling is a repeated pattern. The chosen stages are blocked for a number of cycles equal to the current throttle value, and then run normally for a single cycle. At the end of each pattern the rate is checked again. If it is still above target, the throttle value grows by one, up to a programmable ceiling, and a new pattern starts. Otherwise the block returns to normal running and clears the throttle value.

A stage is blocked by driving its "next stage has a free slot" enable low. Instructions already upstream stay where they are. A mode input picks which stages are blocked: fetch only, commit only, or both together.

Top module: `ipc_throttle_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the throttle value is 0, throttling_o is low, and both enables are high.
- R2: The block is over target when the sum of commit_cnt_i over the last W = 2^WIN_LOG2 sampled cycles is strictly greater than target_ipc_i * W. A sum equal to target * W counts as not over.
- R3: In the normal state both enables are high and the throttle value is 0.
- R4: When the block is over target in the normal state, the next cycle enters throttling with throttle value 1.
- R5: A throttle cycle is exactly N consecutive blocked cycles, where N is the throttle value, followed by exactly one unblocked cycle.
- R6: If the block is over target in that unblocked cycle, the next throttle cycle starts with the throttle value one higher.
- R7: If the block is not over target in that unblocked cycle, the next cycle is in the normal state with throttle value 0.
- R8: The throttle value never exceeds the ceiling tv_max_i and never wraps. A ceiling of 0 is treated as 1.
- R9: mode_i encodes the blocked stages as follows. 0 blocks fetch only. 1 blocks commit only. 2 and 3 block both stages on the same cycles. A stage that is not selected keeps its enable high.
- R10: A target of 2 instructions per cycle is supported through the 3-bit target_ipc_i field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| commit_cnt_i | input | CNT_W | Instructions committed this cycle |
| target_ipc_i | input | TGT_W | Target instructions per cycle |
| tv_max_i | input | TV_W | Throttle value ceiling |
| mode_i | input | 2 | Stage selection for blocking |
| fetch_en_o | output | 1 | Fetch stage slot-available enable |
| commit_en_o | output | 1 | Commit stage slot-available enable |
| throttle_val_o | output | TV_W | Current throttle value |
| throttling_o | output | 1 | High while throttle cycles run |

## Verification
The assertions check the following on every cycle:
- Normal state means both enables are high and the throttle value is 0.
- Mode selection: an unselected stage is never blocked, and in combined mode the two enables always match.
- The throttle value stays at or below its effective ceiling.
- The throttle value only grows by one while throttling, and it starts at 1.

Some behaviour only the bench's scenarios can show:
- The windowed comparison, including the boundary where the window sum equals the target exactly.
- The exact lengths of successive blocked runs as the throttle value escalates and then saturates.
- The return to normal once the commit load drops.

// File: rtl/ipc_throttle_pkg.sv
package ipc_throttle_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_BLOCK  = 2'd1,
    ST_OPEN   = 2'd2
  } thr_state_e;

  typedef enum logic [1:0] {
    MODE_FETCH   = 2'd0,
    MODE_COMMIT  = 2'd1,
    MODE_BOTH    = 2'd2,
    MODE_BOTH_ALT = 2'd3
  } thr_mode_e;
endpackage

// File: rtl/ipc_window.sv
module ipc_window #(
  parameter int CNT_W    = 4,
  parameter int TGT_W    = 3,
  parameter int WIN_LOG2 = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] commit_cnt_i,
  input  logic [TGT_W-1:0] target_ipc_i,
  output logic             over_o
);
  localparam int W     = 1 << WIN_LOG2;
  localparam int SUM_W = CNT_W + WIN_LOG2;
  localparam int CMP_W = (SUM_W > TGT_W + WIN_LOG2) ? SUM_W + 1 : TGT_W + WIN_LOG2 + 1;

  logic [CNT_W-1:0] hist_q [W];
  logic [SUM_W-1:0] sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q[0] <= '0;
    else         hist_q[0] <= commit_cnt_i;
  end

  for (genvar g = 1; g < W; g++) begin : g_hist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q[g] <= '0;
      else         hist_q[g] <= hist_q[g-1];
    end
  end

  // running sum: add newest, drop the one leaving the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= sum_q + SUM_W'(commit_cnt_i) - SUM_W'(hist_q[W-1]);
  end

  logic [CMP_W-1:0] sum_ext, limit_ext;
  always_comb begin
    sum_ext   = CMP_W'(sum_q);
    limit_ext = CMP_W'(target_ipc_i) << WIN_LOG2;
    over_o    = sum_ext > limit_ext;
  end
endmodule

// File: rtl/throttle_fsm.sv
module throttle_fsm
  import ipc_throttle_pkg::*;
#(
  parameter int TV_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            over_i,
  input  logic [TV_W-1:0] tv_max_i,
  output logic            block_o,
  output logic            active_o,
  output logic [TV_W-1:0] tv_o
);
  thr_state_e      state_q, state_d;
  logic [TV_W-1:0] tv_q, tv_d, cnt_q, cnt_d;
  logic [TV_W-1:0] max_eff, tv_inc;

  always_comb begin
    max_eff = (tv_max_i == '0) ? TV_W'(1) : tv_max_i;
    tv_inc  = (tv_q >= max_eff) ? max_eff : tv_q + TV_W'(1);
  end

  always_comb begin
    state_d = state_q;
    tv_d    = tv_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_NORMAL: begin
        if (over_i) begin
          state_d = ST_BLOCK;
          tv_d    = tv_inc;
          cnt_d   = TV_W'(1);
        end
      end
      ST_BLOCK: begin
        if (cnt_q >= tv_q) state_d = ST_OPEN;
        else               cnt_d   = cnt_q + TV_W'(1);
      end
      ST_OPEN: begin
        if (over_i) begin
          state_d = ST_BLOCK;
          tv_d    = tv_inc;
          cnt_d   = TV_W'(1);
        end else begin
          state_d = ST_NORMAL;
          tv_d    = '0;
          cnt_d   = '0;
        end
      end
      default: begin
        state_d = ST_NORMAL;
        tv_d    = '0;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_NORMAL;
      tv_q    <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      tv_q    <= tv_d;
      cnt_q   <= cnt_d;
    end
  end

  assign block_o  = (state_q == ST_BLOCK);
  assign active_o = (state_q != ST_NORMAL);
  assign tv_o     = tv_q;
endmodule

// File: rtl/stage_gate.sv
module stage_gate
  import ipc_throttle_pkg::*;
(
  input  logic       block_i,
  input  logic [1:0] mode_i,
  output logic       fetch_en_o,
  output logic       commit_en_o
);
  logic sel_fetch, sel_commit;

  always_comb begin
    unique case (thr_mode_e'(mode_i))
      MODE_FETCH:  begin sel_fetch = 1'b1; sel_commit = 1'b0; end
      MODE_COMMIT: begin sel_fetch = 1'b0; sel_commit = 1'b1; end
      default:     begin sel_fetch = 1'b1; sel_commit = 1'b1; end
    endcase
    fetch_en_o  = !(block_i && sel_fetch);
    commit_en_o = !(block_i && sel_commit);
  end
endmodule

// File: rtl/ipc_throttle_ctrl.sv
module ipc_throttle_ctrl #(
  parameter int CNT_W    = 4,
  parameter int TGT_W    = 3,
  parameter int WIN_LOG2 = 3,
  parameter int TV_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] commit_cnt_i,
  input  logic [TGT_W-1:0] target_ipc_i,
  input  logic [TV_W-1:0]  tv_max_i,
  input  logic [1:0]       mode_i,
  output logic             fetch_en_o,
  output logic             commit_en_o,
  output logic [TV_W-1:0]  throttle_val_o,
  output logic             throttling_o
);
  logic over, block;

  ipc_window #(
    .CNT_W(CNT_W), .TGT_W(TGT_W), .WIN_LOG2(WIN_LOG2)
  ) win_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_cnt_i (commit_cnt_i),
    .target_ipc_i (target_ipc_i),
    .over_o       (over)
  );

  throttle_fsm #(.TV_W(TV_W)) fsm_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .over_i   (over),
    .tv_max_i (tv_max_i),
    .block_o  (block),
    .active_o (throttling_o),
    .tv_o     (throttle_val_o)
  );

  stage_gate gate_i (
    .block_i     (block),
    .mode_i      (mode_i),
    .fetch_en_o  (fetch_en_o),
    .commit_en_o (commit_en_o)
  );
endmodule

// File: rtl/ipc_throttle_ctrl_chk.sv
module ipc_throttle_ctrl_chk #(
  parameter int TV_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [TV_W-1:0] tv_max_i,
  input logic [1:0]      mode_i,
  input logic            fetch_en_o,
  input logic            commit_en_o,
  input logic [TV_W-1:0] throttle_val_o,
  input logic            throttling_o
);
  logic [TV_W-1:0] max_eff;
  assign max_eff = (tv_max_i == '0) ? TV_W'(1) : tv_max_i;

  // R3
  normal_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !throttling_o |-> (fetch_en_o && commit_en_o && throttle_val_o == '0));

  // R9
  fetch_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0) |-> commit_en_o);

  // R9
  commit_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1) |-> fetch_en_o);

  // R9
  both_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1]) |-> (fetch_en_o == commit_en_o));

  // R8
  tv_ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    throttle_val_o <= max_eff);

  // R4
  entry_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(throttling_o) |-> (throttle_val_o == TV_W'(1)));

  // R6
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (throttling_o && $past(throttling_o) && $stable(tv_max_i) && !$stable(throttle_val_o))
      |-> (throttle_val_o == $past(throttle_val_o) + TV_W'(1)));
endmodule

bind ipc_throttle_ctrl ipc_throttle_ctrl_chk #(.TV_W(TV_W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tv_max_i       (tv_max_i),
  .mode_i         (mode_i),
  .fetch_en_o     (fetch_en_o),
  .commit_en_o    (commit_en_o),
  .throttle_val_o (throttle_val_o),
  .throttling_o   (throttling_o)
);

// File: tb/ipc_throttle_ctrl_tb_top.sv
`timescale 1ns/1ps
module ipc_throttle_ctrl_tb_top;
  localparam int CNT_W = 4, TGT_W = 3, WIN_LOG2 = 3, TV_W = 4;
  localparam int W = 1 << WIN_LOG2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] commit_cnt = '0;
  logic [TGT_W-1:0] target = 3'd2;
  logic [TV_W-1:0]  tv_max = 4'd15;
  logic [1:0]       mode = 2'd2;
  logic             fetch_en, commit_en, throttling;
  logic [TV_W-1:0]  tv;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ipc_throttle_ctrl #(.CNT_W(CNT_W), .TGT_W(TGT_W), .WIN_LOG2(WIN_LOG2), .TV_W(TV_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .commit_cnt_i(commit_cnt), .target_ipc_i(target),
    .tv_max_i(tv_max), .mode_i(mode), .fetch_en_o(fetch_en), .commit_en_o(commit_en),
    .throttle_val_o(tv), .throttling_o(throttling));

  // behavioural reference: 0 normal, 1 blocked, 2 open
  int win[$];
  int m_st = 0, m_tv = 0, m_cnt = 0;
  int runs[$];
  int run = 0;
  int commit_low = 0;

  task automatic model_reset();
    win.delete();
    for (int i = 0; i < W; i++) win.push_back(0);
    m_st = 0; m_tv = 0; m_cnt = 0;
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      int sum, mx, inc;
      bit over;
      sum = 0;
      foreach (win[i]) sum += win[i];
      over = sum > (int'(target) * W);
      mx  = (tv_max == 0) ? 1 : int'(tv_max);
      inc = (m_tv >= mx) ? mx : m_tv + 1;
      case (m_st)
        0: if (over) begin m_st = 1; m_tv = inc; m_cnt = 1; end
        1: if (m_cnt >= m_tv) m_st = 2; else m_cnt++;
        default: if (over) begin m_st = 1; m_tv = inc; m_cnt = 1; end
                 else begin m_st = 0; m_tv = 0; m_cnt = 0; end
      endcase
      void'(win.pop_back());
      win.push_front(int'(commit_cnt));
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ef, ec;
      ef = (m_st == 1 && mode != 2'd1) ? 0 : 1;
      ec = (m_st == 1 && mode != 2'd0) ? 0 : 1;
      check("R5 fetch_en", int'(fetch_en), ef);
      check("R9 commit_en", int'(commit_en), ec);
      check("R6 throttle_val", int'(tv), m_tv);
      check("R7 throttling", int'(throttling), (m_st != 0) ? 1 : 0);
      if (!commit_en) commit_low++;
      if (!fetch_en || !commit_en) run++;
      else if (run > 0) begin runs.push_back(run); run = 0; end
    end
  end

  task automatic do_reset(logic [1:0] md, logic [TV_W-1:0] mx, logic [TGT_W-1:0] tg);
    @(negedge clk); #1;
    rst_n = 1'b0; commit_cnt = '0; mode = md; tv_max = mx; target = tg;
    model_reset();
    #0.5;
    // R1
    check("R1 reset throttle_val", int'(tv), 0);
    check("R1 reset throttling", int'(throttling), 0);
    check("R1 reset enables", int'(fetch_en && commit_en), 1);
    repeat (2) @(negedge clk);
    #1;
    runs.delete(); run = 0; commit_low = 0;
    rst_n = 1'b1;
  endtask

  task automatic drive(int n, int c);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      commit_cnt = CNT_W'(c);
    end
  endtask

  initial begin
    model_reset();
    // R3, R10: light load under target 2
    do_reset(2'd2, 4'd15, 3'd2);
    drive(30, 1);
    check("R3 light load stays normal", int'(throttling), 0);

    // R2: exactly at target is not over
    do_reset(2'd2, 4'd15, 3'd2);
    drive(40, 2);
    check("R2 at-target boundary", int'(throttling), 0);
    check("R2 no blocked runs", runs.size(), 0);

    // R4, R5, R6, R7: escalation then exit, combined mode
    do_reset(2'd2, 4'd15, 3'd2);
    drive(50, 4);
    check("R5 runs seen", (runs.size() >= 4) ? 1 : 0, 1);
    if (runs.size() >= 4) begin
      check("R4 first run length", runs[0], 1);
      check("R6 second run length", runs[1], 2);
      check("R6 third run length", runs[2], 3);
      check("R6 fourth run length", runs[3], 4);
    end
    drive(60, 0);
    check("R7 returned to normal", int'(throttling), 0);
    check("R7 throttle_val cleared", int'(tv), 0);

    // R8: ceiling 3
    do_reset(2'd2, 4'd3, 3'd2);
    drive(80, 6);
    check("R8 runs seen", (runs.size() >= 6) ? 1 : 0, 1);
    if (runs.size() >= 6) begin
      check("R8 run 3", runs[2], 3);
      check("R8 run 4 saturated", runs[3], 3);
      check("R8 run 6 saturated", runs[5], 3);
    end

    // R8: ceiling 0 treated as 1
    do_reset(2'd2, 4'd0, 3'd1);
    drive(40, 5);
    check("R8 zero ceiling run", (runs.size() >= 3 && runs[2] == 1) ? 1 : 0, 1);

    // R9: fetch-only never blocks commit
    do_reset(2'd0, 4'd15, 3'd2);
    drive(50, 7);
    check("R9 fetch-only commit never low", commit_low, 0);
    check("R9 fetch-only throttled", (runs.size() > 0) ? 1 : 0, 1);

    // R9: commit-only and alternate combined code
    do_reset(2'd1, 4'd15, 3'd2);
    drive(50, 7);
    check("R9 commit-only blocks commit", (commit_low > 0) ? 1 : 0, 1);
    do_reset(2'd3, 4'd15, 3'd2);
    drive(50, 7);
    check("R9 mode 3 blocks commit", (commit_low > 0) ? 1 : 0, 1);

    // R2: target 1 with load 1 stays normal, load 2 throttles
    do_reset(2'd2, 4'd15, 3'd1);
    drive(30, 1);
    check("R2 target1 at boundary", int'(throttling), 0);
    drive(12, 2);
    check("R2 target1 over", (runs.size() > 0 || throttling) ? 1 : 0, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule